// File: doc/BRIEF.md
# Banked GPIO Controller Register File

This block holds the control and status state for up to 96 general-purpose pins, grouped in three banks of 32. Pin n is controlled by bit n mod 32 of the registers of bank n/32. A host reaches the block through a simple 32-bit I/O-port style bus: an address, a write strobe, a read strobe, write data and registered read data. Each bank has three registers. A use-select register hands a pin to the GPIO logic instead of its native function. A direction register picks input (1) or output (0). A level register holds the value to drive. For an input pin, the level register reads back the synchronized pad value.

Pins 0 to 31 share one blink-enable register. While a pin's blink bit is set, its driven value follows a free-running blink phase instead of its level bit. Rising edges on pins 0 to 15 are latched into the upper half of a status word. Writing 1 to a status bit clears it. Parameters set four things: how many pins exist, which pins are fixed inputs, which are fixed outputs, and which use-select bits are wired to zero. Pad cells, tristate buffers and interrupt generation sit outside the block.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset, with the default parameters: every implemented pin is an input except the fixed-output pins (direction reads 0xFFFF_FFF3 in bank 0 and 0x0000_00FB in bank 2). Use-select reads 1 for every implemented bit that is not wired to zero (0xFFEC_FFFF in bank 0). Level, blink and status read 0 while all pads are low.
- R2: Register addresses are fixed. Use-select is at 0x00, 0x30 and 0x40 for banks 0, 1 and 2. Direction is at 0x04, 0x34 and 0x44. Level is at 0x0C, 0x38 and 0x48. Blink is at 0x18 and status at 0x60. Pin n maps to bit n mod 32 of bank n/32, and pad_o[n] drives the level written for that pin.
- R3: A direction bit of 0 makes pad_oe_o[n] high when the pin's use-select bit is 1. A direction bit of 1 keeps pad_oe_o[n] low.
- R4: The direction bit of a fixed-input pin always reads 1 and that pin never drives. The direction bit of a fixed-output pin always reads 0. Writes cannot change either bit, so readback differs from the written value. By default pins 40 and 41 are fixed inputs and pins 2, 3 and 66 are fixed outputs.
- R5: Use-select bits in the wired-to-zero mask always read 0 whatever is written. By default these are bits 16, 17 and 20 of bank 0 and bit 16 of bank 1.
- R6: Bits for pins at or above NUM_PINS (default 72) read 0, ignore writes, and never drive pad_o or pad_oe_o.
- R7: A level register read returns the synchronized pad value for input pins and the written level for output pins. The pad value passes through two flops first.
- R8: While blink bit n (n < 32) is set, pad_o[n] toggles every BLINK_HALF cycles (default 8). Clearing the bit returns pad_o[n] to its level bit. Pins in banks 1 and 2 are unaffected.
- R9: A rising edge of synchronized pad n (n < 16) sets status bit 16+n. Falling edges and pins at 16 and above set nothing. Status bits 15:0 always read 0.
- R10: Writing the status register clears each bit 31:16 that is written as 1 and leaves each bit written as 0 unchanged. No status bit clears in any other way.
- R11: When a clear and a new rising edge hit the same status bit in the same cycle, the bit ends up set.
- R12: rdata_o updates on the clock edge that samples rd_i and holds until the next read. Unmapped addresses read 0.
- R13: gpio_sel_o[n] equals use-select bit n. A pin whose use-select bit is 0 never asserts pad_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_i | input | 96 | Raw pad input values |
| pad_o | output | 96 | Value to drive on each pad |
| pad_oe_o | output | 96 | Output enable per pad |
| gpio_sel_o | output | 96 | 1 where a pin is in GPIO mode |

## Verification
The assertions assume that the parameter masks are consistent: no pin is both fixed-input and fixed-output. They also assume that pads are low while reset is asserted, so that no status bit is set by an edge that reset itself creates. The stimulus releases reset with every pad at 0. It changes pads only at the falling clock edge. It waits at least four cycles after a pad change before reading a level or status register, except in the one sequence that deliberately lines a clear up against a fresh edge. Reads of blinking pins are made through pad_o only, never through the level register.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int NBANKS = 3;
  localparam int BANK_W = 32;
  localparam int NPADS  = NBANKS * BANK_W;
  localparam int AW     = 8;
  localparam int EVT_N  = 16;

  localparam logic [AW-1:0] ADDR_BLINK = 8'h18;
  localparam logic [AW-1:0] ADDR_STAT  = 8'h60;

  function automatic logic [AW-1:0] use_addr(input int b);
    case (b)
      0:       return 8'h00;
      1:       return 8'h30;
      default: return 8'h40;
    endcase
  endfunction

  function automatic logic [AW-1:0] dir_addr(input int b);
    case (b)
      0:       return 8'h04;
      1:       return 8'h34;
      default: return 8'h44;
    endcase
  endfunction

  function automatic logic [AW-1:0] lvl_addr(input int b);
    case (b)
      0:       return 8'h0C;
      1:       return 8'h38;
      default: return 8'h48;
    endcase
  endfunction

  function automatic logic [NPADS-1:0] impl_mask(input int num_pins);
    logic [NPADS-1:0] m;
    for (int i = 0; i < NPADS; i++) m[i] = (i < num_pins);
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_blink_tmr.sv
module gpio_blink_tmr #(
  parameter int HALF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter logic [31:0] IMPL    = '1,
  parameter logic [31:0] USE_RO  = '0,
  parameter logic [31:0] FIX_IN  = '0,
  parameter logic [31:0] FIX_OUT = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_use_i,
  input  logic        wr_dir_i,
  input  logic        wr_lvl_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] pad_sync_i,
  input  logic [31:0] blink_en_i,
  input  logic        blink_ph_i,
  output logic [31:0] use_o,
  output logic [31:0] dir_o,
  output logic [31:0] lvl_rd_o,
  output logic [31:0] drive_o,
  output logic [31:0] oe_o
);
  localparam logic [31:0] USE_WMASK = IMPL & ~USE_RO;
  localparam logic [31:0] DIR_RST   = IMPL & ~FIX_OUT;

  logic [31:0] use_q, dir_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q <= USE_WMASK;
      dir_q <= DIR_RST;
      lvl_q <= '0;
    end else begin
      if (wr_use_i) use_q <= wdata_i & USE_WMASK;
      if (wr_dir_i) dir_q <= (wdata_i | FIX_IN) & ~FIX_OUT & IMPL;
      if (wr_lvl_i) lvl_q <= wdata_i & IMPL;
    end
  end

  always_comb begin
    for (int i = 0; i < 32; i++) begin
      drive_o[i] = blink_en_i[i] ? (blink_ph_i & IMPL[i]) : lvl_q[i];
    end
  end

  assign use_o    = use_q;
  assign dir_o    = dir_q;
  assign lvl_rd_o = (dir_q & pad_sync_i) | (~dir_q & lvl_q);
  assign oe_o     = use_q & ~dir_q & IMPL;
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q, evt_q;
  logic [N-1:0] rise;

  assign rise = sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= sync_i;
      // set has priority over a same-cycle clear
      evt_q  <= (evt_q & ~(clr_i ? clr_mask_i : '0)) | rise;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_regs_pkg::*;
#(
  parameter int               NUM_PINS     = 72,
  parameter logic [NPADS-1:0] USE_RO_MASK  = 96'h0_00010000_00130000,
  parameter logic [NPADS-1:0] FIX_IN_MASK  = 96'h0_00000300_00000000,
  parameter logic [NPADS-1:0] FIX_OUT_MASK = 96'h4_00000000_0000000C,
  parameter int               BLINK_HALF   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [NPADS-1:0] pad_i,
  output logic [NPADS-1:0] pad_o,
  output logic [NPADS-1:0] pad_oe_o,
  output logic [NPADS-1:0] gpio_sel_o
);
  localparam logic [NPADS-1:0] IMPL = impl_mask(NUM_PINS);

  logic [NPADS-1:0] pad_sync;
  logic             blink_ph;
  logic [31:0]      blink_q;
  logic [EVT_N-1:0] evt;
  logic [31:0]      use_w [NBANKS];
  logic [31:0]      dir_w [NBANKS];
  logic [31:0]      lvl_w [NBANKS];
  logic [31:0]      rd_mux;

  gpio_sync2 #(.W(NPADS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  gpio_blink_tmr #(.HALF(BLINK_HALF)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(blink_ph)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           blink_q <= '0;
    else if (wr_i && addr_i == ADDR_BLINK) blink_q <= wdata_i & IMPL[31:0];
  end

  gpio_evt_latch #(.N(EVT_N)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (pad_sync[EVT_N-1:0]),
    .clr_i     (wr_i && addr_i == ADDR_STAT),
    .clr_mask_i(wdata_i[31:32-EVT_N]),
    .evt_o     (evt)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [31:0] blink_en;
    if (b == 0) begin : g_blink
      assign blink_en = blink_q;
    end else begin : g_noblink
      assign blink_en = '0;
    end

    gpio_bank #(
      .IMPL   (IMPL[b*32 +: 32]),
      .USE_RO (USE_RO_MASK[b*32 +: 32]),
      .FIX_IN (FIX_IN_MASK[b*32 +: 32]),
      .FIX_OUT(FIX_OUT_MASK[b*32 +: 32])
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_use_i  (wr_i && addr_i == use_addr(b)),
      .wr_dir_i  (wr_i && addr_i == dir_addr(b)),
      .wr_lvl_i  (wr_i && addr_i == lvl_addr(b)),
      .wdata_i   (wdata_i),
      .pad_sync_i(pad_sync[b*32 +: 32]),
      .blink_en_i(blink_en),
      .blink_ph_i(blink_ph),
      .use_o     (use_w[b]),
      .dir_o     (dir_w[b]),
      .lvl_rd_o  (lvl_w[b]),
      .drive_o   (pad_o[b*32 +: 32]),
      .oe_o      (pad_oe_o[b*32 +: 32])
    );

    assign gpio_sel_o[b*32 +: 32] = use_w[b];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (addr_i == use_addr(b)) rd_mux = use_w[b];
      if (addr_i == dir_addr(b)) rd_mux = dir_w[b];
      if (addr_i == lvl_addr(b)) rd_mux = lvl_w[b];
    end
    if (addr_i == ADDR_BLINK) rd_mux = blink_q;
    if (addr_i == ADDR_STAT)  rd_mux = {evt, {(32-EVT_N){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk
  import gpio_regs_pkg::*;
#(
  parameter int               NUM_PINS    = 72,
  parameter logic [NPADS-1:0] USE_RO_MASK = '0,
  parameter logic [NPADS-1:0] FIX_IN_MASK = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [31:0]      rdata_o,
  input logic [NPADS-1:0] pad_o,
  input logic [NPADS-1:0] pad_oe_o,
  input logic [EVT_N-1:0] evt_q_i
);
  localparam logic [NPADS-1:0] IMPL = impl_mask(NUM_PINS);

  AST_FIXIN_NEVER_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & FIX_IN_MASK) == '0); // R4

  AST_UNIMPL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o | pad_oe_o) & ~IMPL) == '0); // R6

  AST_USE_RO_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == use_addr(0) |=> (rdata_o & USE_RO_MASK[31:0]) == '0); // R5

  AST_USE_RO_BANK1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == use_addr(1) |=> (rdata_o & USE_RO_MASK[63:32]) == '0); // R5

  AST_STAT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_STAT |=> rdata_o[31-EVT_N:0] == '0); // R9

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_STAT) |=> (evt_q_i & $past(evt_q_i)) == $past(evt_q_i)); // R10
endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
  .NUM_PINS   (NUM_PINS),
  .USE_RO_MASK(USE_RO_MASK),
  .FIX_IN_MASK(FIX_IN_MASK)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o),
  .evt_q_i (u_evt.evt_q)
);

// File: tb/gpio_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [95:0] pad_i = '0;
  logic [95:0] pad_o, pad_oe_o, gpio_sel_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic  rd_seen = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_bank_regfile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .gpio_sel_o(gpio_sel_o)
  );

  always @(posedge clk_i) rd_seen <= rd_i;

  // monitor: read data is valid the cycle after the strobe
  always @(negedge clk_i) begin
    if (rd_seen) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: got %h exp <none>", rdata_o);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rdata_o !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h exp %h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int edges;
    logic prev;
    idle(5);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    bus_rd(8'h00, 32'hFFEC_FFFF, "R1 use0 reset");
    bus_rd(8'h04, 32'hFFFF_FFF3, "R1 dir0 reset");
    bus_rd(8'h44, 32'h0000_00FB, "R1 dir2 reset");
    bus_rd(8'h0C, 32'h0, "R1 lvl0 reset");
    bus_rd(8'h18, 32'h0, "R1 blink reset");
    bus_rd(8'h60, 32'h0, "R1 stat reset");
    bus_rd(8'h40, 32'h0000_00FF, "R1 use2 reset");

    // R12 unmapped
    bus_rd(8'h7C, 32'h0, "R12 unmapped");

    // R5 wired-zero use bits
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, 32'hFFEC_FFFF, "R5 use0");
    bus_wr(8'h30, 32'hFFFF_FFFF);
    bus_rd(8'h30, 32'hFFFE_FFFF, "R5 use1");

    // R4 fixed direction
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, 32'hFFFF_FFF3, "R4 fixed out dir0");
    bus_wr(8'h34, 32'h0);
    bus_rd(8'h34, 32'h0000_0300, "R4 fixed in dir1");
    bus_wr(8'h34, 32'hFFFF_FFFF);

    // R7 input level via synchronizer
    @(negedge clk_i);
    pad_i[63:32] = 32'hA5A5_0F0F;
    idle(4);
    bus_rd(8'h38, 32'hA5A5_0F0F, "R7 input level");

    // R2/R3 outputs in bank 1
    bus_wr(8'h34, 32'h0);
    bus_wr(8'h38, 32'h1234_5678);
    idle(1);
    chk(pad_oe_o[63:32], 32'hFFFE_FCFF, "R3 oe bank1");
    chk(pad_o[63:32], 32'h1234_5678, "R2 pad_o bank1");
    bus_rd(8'h38, 32'h1234_5778, "R7 mixed level");
    chk(gpio_sel_o[63:32], 32'hFFFE_FFFF, "R13 sel bank1");

    // R13 use gates output enable
    bus_wr(8'h30, 32'h0);
    idle(1);
    chk(pad_oe_o[63:32], 32'h0, "R13 oe off");
    chk(gpio_sel_o[63:32], 32'h0, "R13 sel off");
    bus_wr(8'h30, 32'hFFFF_FFFF);

    // R6 unimplemented pins
    bus_wr(8'h44, 32'h0);
    bus_rd(8'h44, 32'h0, "R6 dir2");
    bus_wr(8'h48, 32'hFFFF_FFFF);
    bus_rd(8'h48, 32'h0000_00FF, "R6 lvl2");
    idle(1);
    chk(pad_o[95:64], 32'h0000_00FF, "R6 pad_o bank2");
    chk(pad_oe_o[95:72], 24'h0, "R6 oe unimpl");

    // R8 blink on fixed-output pin 2
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_rd(8'h18, 32'hFFFF_FFFF, "R8 blink readback");
    edges = 0;
    prev = pad_o[2];
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i);
      if (pad_o[2] !== prev) edges++;
      prev = pad_o[2];
      if (pad_o[63:32] !== 32'h1234_5678) chk(pad_o[63:32], 32'h1234_5678, "R8 bank1 steady");
    end
    chk(96'(edges), 96'd4, "R8 blink toggles per 32 cycles");
    bus_wr(8'h18, 32'h0);
    idle(1);
    chk(pad_o[3:2], 2'b00, "R8 blink off");

    // R9 rising edges latch
    @(negedge clk_i);
    pad_i[5] = 1'b1; pad_i[9] = 1'b1; pad_i[20] = 1'b1;
    idle(4);
    bus_rd(8'h60, 32'h0220_0000, "R9 latched edges");

    // R10 w1c
    bus_wr(8'h60, 32'h0020_0000);
    bus_rd(8'h60, 32'h0200_0000, "R10 clear one");
    bus_wr(8'h60, 32'h0);
    bus_rd(8'h60, 32'h0200_0000, "R10 zero keeps");
    bus_wr(8'h60, 32'hFFFF_0000);
    bus_rd(8'h60, 32'h0, "R10 clear all");

    // R11 set wins over clear
    @(negedge clk_i);
    pad_i[5] = 1'b0;
    idle(4);
    pad_i[5] = 1'b1;        // edge sampled at next posedge k; rise at k+2
    @(negedge clk_i);
    @(negedge clk_i);
    addr_i = 8'h60; wdata_i = 32'h0020_0000; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    idle(3);
    bus_rd(8'h60, 32'h0020_0000, "R11 set wins");

    // R9 falling edge ignored
    @(negedge clk_i);
    pad_i[9] = 1'b0;
    idle(4);
    bus_rd(8'h60, 32'h0020_0000, "R9 fall ignored");

    idle(2);
    chk(96'(sb_q.size()), 96'd0, "R12 scoreboard drained");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule